// File: doc/BRIEF.md
# Peripheral Control-Line and Interrupt Controller

This block sits beside two parallel ports and handles everything except the data and direction registers. It watches two edge-sensing input lines (CA1, CB1). It runs two line-2 pins (CA2, CB2), and each of these can be an edge-sensing input or a driven output. Each port has an optional input hold register that captures the port pins on the line-1 edge. The block also gathers seven interrupt sources into a flag register, masks them with an enable register, and drives an active-low interrupt request.

A small register bus reaches four registers: address 0 is the line control register, address 1 is the hold-enable register, address 2 holds the flags and address 3 holds the enables. The enclosing port logic drives access strobes. Port A accesses can arrive through a quiet alias, which has no side effects. The timers and the shift register report through set and clear pulses.

Top module: `hsk_irq_ctrl`

## Requirements
- R1: `irq_n` is low exactly when some flag bit and its matching enable bit are both 1. Flag register bit 7 reads 1 under the same condition.
- R2: A write to address 2 clears every flag whose written bit (6..0) is 1. Bit 7 is never stored. The `t1_clr`, `t2_clr` and `sr_clr` pulses clear flags 6, 5 and 2. The `t1_set`, `t2_set` and `sr_set` pulses set those same flags.
- R3: A write to address 3 with bit 7 = 1 sets each enable whose written bit is 1. With bit 7 = 0 it clears each such enable. Written 0 bits leave their enables unchanged. Address 3 reads back with bit 7 = 1.
- R4: Control bit 0 (CA1) and control bit 4 (CB1) choose the active edge: 0 selects falling and 1 selects rising. An active edge sets flag 1 (CA1) or flag 4 (CB1). The opposite edge sets nothing.
- R5: Control bit 3 (CA2) or bit 7 (CB2) set to 0 makes that line an input. Bit 2 or bit 6 then picks its active edge (0 falling, 1 rising). The edge sets flag 0 (CA2) or flag 3 (CB2).
- R6: A port A access clears flags 1 and 0. A port B access clears flags 4 and 3. If the line-2 pin is an input with its independent bit set (bit 1 for CA2, bit 5 for CB2), its flag is left set.
- R7: In output mode, bits 2..1 (CA2) and bits 6..5 (CB2) select the output behaviour:
  - 00 handshake: a port write drives the line low, and the next line-1 active edge returns it high.
  - 01 pulse: a port write gives a low level for exactly one cycle.
  - 10: the line is held low.
  - 11: the line is held high.
  - The output-enable pin follows bit 3 (CA2) or bit 7 (CB2).
- R8: A port A access marked `pa_alias` leaves the flags and CA2 unchanged.
- R9: When hold-enable bit 0 (port A) or bit 1 (port B) is set, the port view shows the pins captured at the last line-1 active edge. When the bit is clear, it shows the live pins.
- R10: If a flag is set and cleared in the same cycle, the set wins.
- R11: After reset, all flags, enables, control bits and hold enables are 0, `irq_n` is high and both line-2 pins are inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pa_stb | input | 1 | Port A access strobe |
| pa_we | input | 1 | Port A access is a write |
| pa_alias | input | 1 | Port A access goes through the quiet alias |
| pb_stb | input | 1 | Port B access strobe |
| pb_we | input | 1 | Port B access is a write |
| pa_pins | input | PW | Port A pin levels |
| pb_pins | input | PW | Port B pin levels |
| pa_view | output | PW | Port A input value (held or live) |
| pb_view | output | PW | Port B input value (held or live) |
| t1_set | input | 1 | Timer 1 flag set pulse |
| t1_clr | input | 1 | Timer 1 flag clear pulse |
| t2_set | input | 1 | Timer 2 flag set pulse |
| t2_clr | input | 1 | Timer 2 flag clear pulse |
| sr_set | input | 1 | Shift register flag set pulse |
| sr_clr | input | 1 | Shift register flag clear pulse |
| ca1_i | input | 1 | Port A line-1 input |
| ca2_i | input | 1 | Port A line-2 input level |
| ca2_o | output | 1 | Port A line-2 output level |
| ca2_oe | output | 1 | Port A line-2 output enable |
| cb1_i | input | 1 | Port B line-1 input |
| cb2_i | input | 1 | Port B line-2 input level |
| cb2_o | output | 1 | Port B line-2 output level |
| cb2_oe | output | 1 | Port B line-2 output enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with PW = 4. This keeps the hold registers narrow while the control byte still covers all line modes. With the narrow width, the bench sweeps every flag-clear mask, all 128 enable patterns against a fixed flag set, and a long computed series of enable writes. It checks the result of each against arithmetic in the bench. For each of the four control lines it steps both edge polarities, and it walks every output mode, the independent-clear option and the quiet alias.

// File: rtl/hsk_irq_ctrl.sv
module hsk_irq_ctrl #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          pa_stb,
  input  logic          pa_we,
  input  logic          pa_alias,
  input  logic          pb_stb,
  input  logic          pb_we,
  input  logic [PW-1:0] pa_pins,
  input  logic [PW-1:0] pb_pins,
  output logic [PW-1:0] pa_view,
  output logic [PW-1:0] pb_view,
  input  logic          t1_set,
  input  logic          t1_clr,
  input  logic          t2_set,
  input  logic          t2_clr,
  input  logic          sr_set,
  input  logic          sr_clr,
  input  logic          ca1_i,
  input  logic          ca2_i,
  output logic          ca2_o,
  output logic          ca2_oe,
  input  logic          cb1_i,
  input  logic          cb2_i,
  output logic          cb2_o,
  output logic          cb2_oe,
  output logic          irq_n
);

  localparam int NF = 7;

  logic [7:0]    pcr_q;
  logic [1:0]    hold_en_q;
  logic [NF-1:0] flag_q, ena_q, fl_set, fl_clr;
  logic [3:0]    prev_q, pin_now, pol, act;
  logic          armed_q;
  logic          hs_a_q, hs_b_q, pul_a_q, pul_b_q;
  logic [PW-1:0] hold_a_q, hold_b_q;
  logic          wr_pcr, wr_hold, wr_ifr, wr_ier;
  logic          a_acc, b_acc, a_wr, b_wr;
  logic          ca1_edge, ca2_edge, cb1_edge, cb2_edge;
  logic          ca2_keep, cb2_keep, any_irq;

  assign wr_pcr  = bus_we && bus_addr == 2'd0;
  assign wr_hold = bus_we && bus_addr == 2'd1;
  assign wr_ifr  = bus_we && bus_addr == 2'd2;
  assign wr_ier  = bus_we && bus_addr == 2'd3;

  assign a_acc = pa_stb && !pa_alias;
  assign b_acc = pb_stb;
  assign a_wr  = a_acc && pa_we;
  assign b_wr  = b_acc && pb_we;

  assign pin_now = {cb2_i, cb1_i, ca2_i, ca1_i};
  assign pol     = {pcr_q[6], pcr_q[4], pcr_q[2], pcr_q[0]};
  assign act     = armed_q ? ((pol & pin_now & ~prev_q) | (~pol & ~pin_now & prev_q)) : 4'b0;

  assign ca1_edge = act[0];
  assign ca2_edge = act[1] && !pcr_q[3];
  assign cb1_edge = act[2];
  assign cb2_edge = act[3] && !pcr_q[7];

  assign ca2_keep = !pcr_q[3] && pcr_q[1];
  assign cb2_keep = !pcr_q[7] && pcr_q[5];

  assign fl_set = {t1_set, t2_set, cb1_edge, cb2_edge, sr_set, ca1_edge, ca2_edge};
  assign fl_clr = {t1_clr, t2_clr, b_acc, b_acc && !cb2_keep, sr_clr, a_acc, a_acc && !ca2_keep}
                | (wr_ifr ? bus_wdata[NF-1:0] : {NF{1'b0}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcr_q     <= '0;
      hold_en_q <= '0;
      flag_q    <= '0;
      ena_q     <= '0;
      prev_q    <= '0;
      armed_q   <= 1'b0;
    end else begin
      prev_q  <= pin_now;
      armed_q <= 1'b1;
      flag_q  <= (flag_q & ~fl_clr) | fl_set;
      if (wr_pcr)  pcr_q     <= bus_wdata;
      if (wr_hold) hold_en_q <= bus_wdata[1:0];
      if (wr_ier)
        ena_q <= bus_wdata[7] ? (ena_q | bus_wdata[NF-1:0]) : (ena_q & ~bus_wdata[NF-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_a_q  <= 1'b1;
      hs_b_q  <= 1'b1;
      pul_a_q <= 1'b0;
      pul_b_q <= 1'b0;
    end else begin
      if (pcr_q[3:1] != 3'b100) hs_a_q <= 1'b1;
      else if (a_wr)            hs_a_q <= 1'b0;
      else if (ca1_edge)        hs_a_q <= 1'b1;
      if (pcr_q[7:5] != 3'b100) hs_b_q <= 1'b1;
      else if (b_wr)            hs_b_q <= 1'b0;
      else if (cb1_edge)        hs_b_q <= 1'b1;
      pul_a_q <= a_wr && pcr_q[3:1] == 3'b101;
      pul_b_q <= b_wr && pcr_q[7:5] == 3'b101;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_a_q <= '0;
      hold_b_q <= '0;
    end else begin
      if (ca1_edge) hold_a_q <= pa_pins;
      if (cb1_edge) hold_b_q <= pb_pins;
    end
  end

  assign pa_view = hold_en_q[0] ? hold_a_q : pa_pins;
  assign pb_view = hold_en_q[1] ? hold_b_q : pb_pins;

  always_comb begin
    ca2_o = 1'b1;
    if (pcr_q[3])
      case (pcr_q[2:1])
        2'b00:   ca2_o = hs_a_q;
        2'b01:   ca2_o = !pul_a_q;
        2'b10:   ca2_o = 1'b0;
        default: ca2_o = 1'b1;
      endcase
    cb2_o = 1'b1;
    if (pcr_q[7])
      case (pcr_q[6:5])
        2'b00:   cb2_o = hs_b_q;
        2'b01:   cb2_o = !pul_b_q;
        2'b10:   cb2_o = 1'b0;
        default: cb2_o = 1'b1;
      endcase
  end

  assign ca2_oe  = pcr_q[3];
  assign cb2_oe  = pcr_q[7];
  assign any_irq = |(flag_q & ena_q);
  assign irq_n   = !any_irq;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = pcr_q;
      2'd1:    bus_rdata = {6'b0, hold_en_q};
      2'd2:    bus_rdata = {any_irq, flag_q};
      default: bus_rdata = {1'b1, ena_q};
    endcase
  end

endmodule

module hsk_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [6:0] ena_q,
  input logic [6:0] flag_q,
  input logic [6:0] fl_set,
  input logic [7:0] pcr_q,
  input logic       ca2_o,
  input logic       a_wr
);

  p_ena_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd3 && bus_wdata[7])
      |=> ((ena_q & $past(bus_wdata[6:0])) == $past(bus_wdata[6:0])));

  p_ena_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd3 && !bus_wdata[7])
      |=> ((ena_q & $past(bus_wdata[6:0])) == 7'd0));

  p_flag_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd2)
      |=> ((flag_q & $past(bus_wdata[6:0] & ~fl_set)) == 7'd0));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|fl_set) |=> ((flag_q & $past(fl_set)) == $past(fl_set)));

  p_pulse_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pcr_q[3:1] == 3'b101 && !ca2_o && !a_wr && !(bus_we && bus_addr == 2'd0))
      |=> ca2_o);

  p_hs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pcr_q[3:1] == 3'b100 && a_wr && !(bus_we && bus_addr == 2'd0))
      |=> !ca2_o);

endmodule

bind hsk_irq_ctrl hsk_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ena_q(ena_q), .flag_q(flag_q), .fl_set(fl_set),
  .pcr_q(pcr_q), .ca2_o(ca2_o), .a_wr(a_wr)
);

// File: tb/hsk_irq_ctrl_test.sv
module hsk_irq_ctrl_test;
  localparam int PW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 0; logic [1:0] bus_addr = 0; logic [7:0] bus_wdata = 0; logic [7:0] bus_rdata;
  logic pa_stb = 0, pa_we = 0, pa_alias = 0, pb_stb = 0, pb_we = 0;
  logic [PW-1:0] pa_pins = 0, pb_pins = 0, pa_view, pb_view;
  logic t1_set = 0, t1_clr = 0, t2_set = 0, t2_clr = 0, sr_set = 0, sr_clr = 0;
  logic ca1_i = 0, ca2_i = 0, cb1_i = 0, cb2_i = 0;
  logic ca2_o, ca2_oe, cb2_o, cb2_oe, irq_n;
  int ntest = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hsk_irq_ctrl #(.PW(PW)) uut (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1; tick(); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic porta(input logic w, input logic al);
    pa_stb = 1; pa_we = w; pa_alias = al; tick(); pa_stb = 0; pa_we = 0; pa_alias = 0;
  endtask

  task automatic portb(input logic w);
    pb_stb = 1; pb_we = w; tick(); pb_stb = 0; pb_we = 0;
  endtask

  task automatic set_line(input int n, input logic v);
    case (n)
      0: ca1_i = v; 1: ca2_i = v; 2: cb1_i = v; default: cb2_i = v;
    endcase
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      ntest++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    logic [6:0] em;
    @(negedge clk); tick(); tick();
    rd(2, v); chk("R11 flags", v, 8'h00);
    rd(3, v); chk("R11 enables", v, 8'h80);
    rd(0, v); chk("R11 control", v, 8'h00);
    rd(1, v); chk("R11 hold", v, 8'h00);
    chk("R11 irq_n", irq_n, 1'b1);
    chk("R11 oe", {ca2_oe, cb2_oe}, 2'b00);
    rst_n = 1; tick(); tick();

    em = 0;
    for (int i = 0; i < 256; i++) begin
      v = 8'((i * 73 + 5) & 255);
      wr(3, v);
      em = v[7] ? (em | v[6:0]) : (em & ~v[6:0]);
      rd(3, v); chk("R3 enable sweep", v, {1'b1, em});
    end
    wr(3, 8'h7f);

    for (int m = 0; m < 128; m++) begin
      t1_set = 1; t2_set = 1; sr_set = 1; tick(); t1_set = 0; t2_set = 0; sr_set = 0;
      wr(2, 8'(m));
      rd(2, v); chk("R2 clear mask", v, {1'b0, 7'h64 & ~7'(m)});
      wr(2, 8'h7f);
    end

    t1_set = 1; t2_set = 1; sr_set = 1; tick(); t1_set = 0; t2_set = 0; sr_set = 0;
    for (int e = 0; e < 128; e++) begin
      wr(3, 8'h7f); wr(3, 8'h80 | 8'(e));
      chk("R1 irq_n", irq_n, !((7'(e) & 7'h64) != 0));
      rd(2, v); chk("R1 bit7", v[7], ((7'(e) & 7'h64) != 0));
    end
    wr(3, 8'h7f);
    t2_clr = 1; tick(); t2_clr = 0;
    rd(2, v); chk("R2 t2_clr", v, 8'h44);
    t1_clr = 1; sr_clr = 1; tick(); t1_clr = 0; sr_clr = 0;
    rd(2, v); chk("R2 t1/sr clr", v, 8'h00);

    t1_set = 1; bus_addr = 2; bus_wdata = 8'h40; bus_we = 1; tick(); bus_we = 0; t1_set = 0;
    rd(2, v); chk("R10 set wins", v, 8'h40);
    wr(2, 8'h7f);

    for (int n = 0; n < 4; n++) begin
      for (int p = 0; p < 2; p++) begin
        int fb;
        fb = (n == 0) ? 1 : (n == 1) ? 0 : (n == 2) ? 4 : 3;
        wr(0, 8'(p << (2 * n)));
        set_line(n, p[0]); tick(); tick(); wr(2, 8'h7f);
        set_line(n, !p[0]); tick();
        rd(2, v); chk(n < 2 || n == 2 ? ((n == 1) ? "R5 inactive edge" : "R4 inactive edge") : "R5 inactive edge", v, 8'h00);
        set_line(n, p[0]); tick();
        rd(2, v); chk((n == 0 || n == 2) ? "R4 active edge" : "R5 active edge", v, 8'(1 << fb));
        wr(2, 8'h7f);
      end
    end
    ca1_i = 0; ca2_i = 0; cb1_i = 0; cb2_i = 0; tick(); wr(2, 8'h7f);

    wr(0, 8'h05);
    ca1_i = 1; ca2_i = 1; tick();
    rd(2, v); chk("R6 set A", v, 8'h03);
    porta(1'b1, 1'b1); porta(1'b0, 1'b1);
    rd(2, v); chk("R8 alias keeps flags", v, 8'h03);
    portb(1'b0);
    rd(2, v); chk("R6 port B leaves A", v, 8'h03);
    porta(1'b0, 1'b0);
    rd(2, v); chk("R6 normal clear A", v, 8'h00);
    wr(0, 8'h07);
    ca1_i = 0; ca2_i = 0; tick(); ca1_i = 1; ca2_i = 1; tick();
    porta(1'b1, 1'b0);
    rd(2, v); chk("R6 independent CA2", v, 8'h01);
    wr(2, 8'h7f);
    wr(0, 8'h50);
    cb1_i = 1; cb2_i = 1; tick();
    rd(2, v); chk("R6 set B", v, 8'h18);
    portb(1'b1);
    rd(2, v); chk("R6 normal clear B", v, 8'h00);
    wr(0, 8'h70);
    cb1_i = 0; cb2_i = 0; tick(); cb1_i = 1; cb2_i = 1; tick();
    portb(1'b0);
    rd(2, v); chk("R6 independent CB2", v, 8'h08);
    wr(2, 8'h7f);

    ca1_i = 0; wr(0, 8'h09); tick();
    chk("R7 oe A", ca2_oe, 1'b1);
    chk("R7 handshake idle", ca2_o, 1'b1);
    porta(1'b1, 1'b1);
    chk("R8 alias no handshake", ca2_o, 1'b1);
    porta(1'b1, 1'b0);
    chk("R7 handshake low", ca2_o, 1'b0);
    tick(); tick();
    chk("R7 handshake holds", ca2_o, 1'b0);
    ca1_i = 1; tick();
    chk("R7 handshake release", ca2_o, 1'b1);
    wr(0, 8'h0b);
    porta(1'b1, 1'b0);
    chk("R7 pulse low", ca2_o, 1'b0);
    tick();
    chk("R7 pulse one cycle", ca2_o, 1'b1);
    wr(0, 8'h0d); chk("R7 const low A", ca2_o, 1'b0);
    wr(0, 8'h0f); chk("R7 const high A", ca2_o, 1'b1);

    cb1_i = 1; wr(0, 8'h80); tick();
    chk("R7 oe B", {cb2_oe, ca2_oe}, 2'b10);
    portb(1'b1);
    chk("R7 B handshake low", cb2_o, 1'b0);
    cb1_i = 0; tick();
    chk("R7 B handshake release", cb2_o, 1'b1);
    wr(0, 8'ha0); portb(1'b1);
    chk("R7 B pulse low", cb2_o, 1'b0);
    tick(); chk("R7 B pulse end", cb2_o, 1'b1);
    wr(0, 8'hc0); chk("R7 B const low", cb2_o, 1'b0);
    wr(0, 8'he0); chk("R7 B const high", cb2_o, 1'b1);

    ca1_i = 0; cb1_i = 0;
    wr(0, 8'h11); wr(1, 8'h03);
    rd(1, v); chk("R9 hold reg", v, 8'h03);
    pa_pins = 4'ha; pb_pins = 4'h6; ca1_i = 1; cb1_i = 1; tick();
    pa_pins = 4'h5; pb_pins = 4'h9; tick();
    chk("R9 held A", pa_view, 4'ha);
    chk("R9 held B", pb_view, 4'h6);
    ca1_i = 0; tick();
    pa_pins = 4'h3; tick();
    chk("R9 falling ignored", pa_view, 4'ha);
    wr(1, 8'h00);
    chk("R9 live A", pa_view, 4'h3);
    chk("R9 live B", pb_view, 4'h9);

    done = 1;
    finish_run();
  end
endmodule